// File: doc/BRIEF.md
# Single-Cycle 16-bit RISC Core

This block is a compact processor core that completes one instruction in every clock cycle. Each cycle it presents a 7-bit program counter to an external instruction memory and receives the 16-bit word at that address. It decodes the word and performs one operation: an arithmetic or logic step, a constant load, a data-memory access, a conditional or unconditional jump, a call, or a return. Programs are limited to 128 words.

The core holds eight 16-bit general registers and four status flags: zero, negative, carry and overflow. The data-memory port reads combinationally and writes on the clock edge. All state is cleared by an asynchronous active-low reset. The core leaves reset on a clock edge, after a two-stage synchronizer.

Every instruction carries a 4-bit opcode in bits [15:12]. Register fields are 3 bits wide, and register code n selects register n.

Top module: `risc16_core`

## Requirements
- R1: While reset is asserted, and until the internal reset release, the program counter is 0 and the data write enable is low. Leaving reset, all registers and all flags are zero.
- R2: `imem_addr` shows the program counter. A non-branching instruction advances it by one, and it wraps from 127 to 0.
- R3: Register format: rd in [11:9], rs0 in [8:6], rs1 in [5:3]. Opcode 0000 writes rs0+rs1, 0001 writes rs0-rs1, 0101 writes rs0 AND rs1, 0110 writes rs0 OR rs1, and 0111 writes NOT rs0. Each result goes to rd.
- R4: Using rs0 only, opcode 0010 shifts left by one, 0011 shifts right by one with a zero fill, and 0100 shifts right by one keeping the sign bit.
- R5: Flags change only on opcodes 0000-0111. Z is set when the result is zero and N is the result's bit 15. C is the carry out for add, the borrow (rs0 < rs1 unsigned) for subtract, the bit shifted out for shifts, and 0 for AND/OR/NOT. V is signed overflow for add and subtract and 0 otherwise.
- R6: Opcode 1000 writes rd ([11:9]) with bits [7:0] zero-extended to 16 bits. Bit 8 is ignored.
- R7: Opcode 1010 tests a mask in [11:8], where bit 11 selects Z, bit 10 N, bit 9 C and bit 8 V. The branch is taken when any selected flag is set, and the new PC is its own address plus the signed offset in [7:0], modulo 128.
- R8: Opcode 1011 always jumps to its own address plus the signed offset in [11:0], modulo 128. An offset of 0 holds the PC.
- R9: Opcodes 1100 (load) and 1101 (store) address memory at register [8:6] plus the zero-extended [5:0]. A load writes the read data into rd ([11:9]). A store drives rd's value and raises the write enable for that cycle only.
- R10: Opcode 1110 writes the address of the next instruction into the register named by [11:9], and jumps to the low 7 bits of [7:0].
- R11: Opcode 1111 jumps to the low 7 bits of the register named by [11:9].
- R12: Opcode 1001 is a no-op whatever its low bits are. It changes no register, flag or memory, and the PC advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 7 | Program counter to instruction memory |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 16 | Data memory address |
| dmem_wdata | output | 16 | Data memory write data |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 16 | Data memory read data (combinational) |

## Verification
The bench runs small programs and reads results back through stores. It aims at cases that are easy to get wrong:
- **Carry and borrow on subtract.** A design that inverted this would take the wrong side of a carry branch after subtracting 1 from 0.
- **Overflow from a mixed-sign subtract.** A design that got this wrong would miss it.
- **Backward branch that wraps below address 0, then sequential wrap from 127.** A design that sign-extended offsets badly would run away instead of reaching the halt address.
- **Call-link value and return through a register other than r7.** Errors here would store the wrong link.
- **Constants with the reserved bit set, and no-ops with stray low bits.** A design that got these wrong would corrupt a register or write memory.

// File: rtl/risc16_pkg.sv
package risc16_pkg;
  localparam int RAW  = 3;
  localparam int NREG = 1 << RAW;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB = 4'h1, OP_SHL = 4'h2, OP_LSR = 4'h3,
    OP_ASR  = 4'h4, OP_AND = 4'h5, OP_OR  = 4'h6, OP_NOT = 4'h7,
    OP_LDI  = 4'h8, OP_NOP = 4'h9, OP_BCC = 4'hA, OP_BRA = 4'hB,
    OP_LD   = 4'hC, OP_ST  = 4'hD, OP_CALL = 4'hE, OP_RET = 4'hF
  } op_e;

  // bit order matches the condition mask field of the conditional branch
  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [1:0] {PC_SEQ, PC_REL, PC_ABS} pcsel_e;
endpackage

// File: rtl/risc16_rstsync.sv
module risc16_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/risc16_regfile.sv
module risc16_regfile import risc16_pkg::*; #(
  parameter int DW  = 16,
  parameter int NRD = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [RAW-1:0]           waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][RAW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
    if (we) regs_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = regs_q[raddr[p]];
  end

  // R3
  rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/risc16_alu.sv
module risc16_alu import risc16_pkg::*; #(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output flags_t        fl
);
  localparam int MSB = DW - 1;
  logic [DW:0] wide;

  always_comb begin
    wide = '0;
    res  = '0;
    fl   = '0;
    case (op)
      OP_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        res  = wide[DW-1:0];
        fl.c = wide[DW];
        fl.v = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_SUB: begin
        wide = {1'b0, a} - {1'b0, b};
        res  = wide[DW-1:0];
        fl.c = wide[DW];
        fl.v = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_SHL: begin res = {a[DW-2:0], 1'b0};    fl.c = a[MSB]; end
      OP_LSR: begin res = {1'b0, a[DW-1:1]};    fl.c = a[0];   end
      OP_ASR: begin res = {a[MSB], a[DW-1:1]};  fl.c = a[0];   end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_NOT: res = ~a;
      default: res = '0;
    endcase
    fl.z = (res == '0);
    fl.n = res[MSB];
  end
endmodule

// File: rtl/risc16_pcunit.sv
module risc16_pcunit import risc16_pkg::*; #(
  parameter int PCW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  pcsel_e         sel,
  input  logic [PCW-1:0] rel_off,
  input  logic [PCW-1:0] abs_tgt,
  output logic [PCW-1:0] pc_o,
  output logic [PCW-1:0] pc_inc_o
);
  logic [PCW-1:0] pc_q, pc_d;

  assign pc_inc_o = pc_q + PCW'(1);

  always_comb begin
    case (sel)
      PC_REL:  pc_d = pc_q + rel_off;
      PC_ABS:  pc_d = abs_tgt;
      default: pc_d = pc_inc_o;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == PC_SEQ) |=> (pc_q == $past(pc_q) + PCW'(1)));
endmodule

// File: rtl/risc16_core.sv
module risc16_core import risc16_pkg::*; #(
  parameter int DW  = 16,
  parameter int PCW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [PCW-1:0] imem_addr,
  input  logic [15:0]    imem_data,
  output logic [DW-1:0]  dmem_addr,
  output logic [DW-1:0]  dmem_wdata,
  output logic           dmem_we,
  input  logic [DW-1:0]  dmem_rdata
);
  localparam int NRD = 3;
  localparam int IMM = 8;

  logic             srst_n;
  op_e              op;
  logic             is_alu;
  logic [RAW-1:0]   f_rd, f_rs0, f_rs1;
  logic [NRD-1:0][RAW-1:0] raddr;
  logic [NRD-1:0][DW-1:0]  rdata;
  logic [DW-1:0]    alu_res, rf_wdata;
  logic             rf_we, st_en;
  flags_t           alu_fl, flags_q;
  pcsel_e           pc_sel;
  logic [PCW-1:0]   pc_q, pc_inc, abs_tgt;

  risc16_rstsync #(.STAGES(2)) u_rsync (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  assign op     = op_e'(imem_data[15:12]);
  assign is_alu = ~imem_data[15];
  assign f_rd   = imem_data[11:9];
  assign f_rs0  = imem_data[8:6];
  assign f_rs1  = imem_data[5:3];
  // port 0: rs0 / pointer, port 1: rs1, port 2: rd (store data, return target)
  assign raddr  = {f_rd, f_rs1, f_rs0};

  risc16_regfile #(.DW(DW), .NRD(NRD)) u_rf (
    .clk(clk), .rst_n(srst_n), .we(rf_we), .waddr(f_rd), .wdata(rf_wdata),
    .raddr(raddr), .rdata(rdata));

  risc16_alu #(.DW(DW)) u_alu (
    .op(op), .a(rdata[0]), .b(rdata[1]), .res(alu_res), .fl(alu_fl));

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = alu_res;
    st_en    = 1'b0;
    pc_sel   = PC_SEQ;
    abs_tgt  = imem_data[PCW-1:0];
    if (is_alu) rf_we = 1'b1;
    case (op)
      OP_LDI: begin
        rf_we    = 1'b1;
        rf_wdata = {{(DW-IMM){1'b0}}, imem_data[IMM-1:0]};
      end
      OP_LD: begin
        rf_we    = 1'b1;
        rf_wdata = dmem_rdata;
      end
      OP_ST:  st_en = 1'b1;
      OP_BCC: if (|(imem_data[11:8] & flags_q)) pc_sel = PC_REL;
      OP_BRA: pc_sel = PC_REL;
      OP_CALL: begin
        rf_we    = 1'b1;
        rf_wdata = {{(DW-PCW){1'b0}}, pc_inc};
        pc_sel   = PC_ABS;
      end
      OP_RET: begin
        pc_sel  = PC_ABS;
        abs_tgt = rdata[2][PCW-1:0];
      end
      default: ;
    endcase
  end

  // offsets are taken modulo 2**PCW, so their low PCW bits suffice
  risc16_pcunit #(.PCW(PCW)) u_pc (
    .clk(clk), .rst_n(srst_n), .sel(pc_sel), .rel_off(imem_data[PCW-1:0]),
    .abs_tgt(abs_tgt), .pc_o(pc_q), .pc_inc_o(pc_inc));

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     flags_q <= '0;
    else if (is_alu) flags_q <= alu_fl;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = rdata[0] + {{(DW-6){1'b0}}, imem_data[5:0]};
  assign dmem_wdata = rdata[2];
  assign dmem_we    = st_en & srst_n;

  // R1
  pc_rst_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (imem_addr == '0));
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    imem_data[15] |=> $stable(flags_q));
  // R9
  st_only_chk: assert property (@(posedge clk) disable iff (!srst_n)
    dmem_we |-> (imem_data[15:12] == 4'b1101));
  // R10
  call_tgt_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (imem_data[15:12] == 4'b1110) |=> (imem_addr == $past(imem_data[PCW-1:0])));
  // R11
  ret_tgt_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (imem_data[15:12] == 4'b1111) |=> (imem_addr == $past(dmem_wdata[PCW-1:0])));
endmodule

// File: tb/risc16_core_tb.sv
module risc16_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  imem_addr;
  logic [15:0] imem_data;
  logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [15:0] rom  [128];
  logic [15:0] dmem [256];
  int nchk = 0, nfail = 0, wcount = 0, wp = 0;

  always #2 clk = ~clk;

  risc16_core u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata));

  assign imem_data  = rom[imem_addr];
  assign dmem_rdata = dmem[dmem_addr[7:0]];

  always @(posedge clk) begin
    if (dmem_we) begin
      dmem[dmem_addr[7:0]] = dmem_wdata;
      wcount = wcount + 1;
    end
  end

  function automatic logic [15:0] f_r(logic [3:0] op, logic [2:0] d, logic [2:0] a, logic [2:0] b);
    return {op, d, a, b, 3'b000};
  endfunction
  function automatic logic [15:0] f_li(logic [2:0] d, logic [7:0] imm);
    return {4'h8, d, 1'b0, imm};
  endfunction
  function automatic logic [15:0] f_bc(logic [3:0] mask, int off);
    return {4'hA, mask, off[7:0]};
  endfunction
  function automatic logic [15:0] f_b(int off);
    return {4'hB, off[11:0]};
  endfunction
  function automatic logic [15:0] f_ld(logic [2:0] d, logic [2:0] p, logic [5:0] off);
    return {4'hC, d, p, off};
  endfunction
  function automatic logic [15:0] f_st(logic [2:0] d, logic [2:0] p, logic [5:0] off);
    return {4'hD, d, p, off};
  endfunction
  function automatic logic [15:0] f_call(logic [2:0] d, logic [7:0] tgt);
    return {4'hE, d, 1'b0, tgt};
  endfunction
  function automatic logic [15:0] f_ret(logic [2:0] r);
    return {4'hF, r, 9'b0};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic emit(logic [15:0] w);
    rom[wp] = w;
    wp++;
  endtask

  task automatic load_start();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 128; i++) rom[i] = 16'h9000;
    for (int i = 0; i < 256; i++) dmem[i] = 16'hDEAD;
    wp = 0;
    wcount = 0;
  endtask

  task automatic run(int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    load_start();
    emit(f_st(3'd3, 3'd0, 6'd5));
    emit(f_li(3'd1, 8'h33));
    emit(f_bc(4'b1111, 2));
    emit(f_li(3'd1, 8'h44));
    emit(f_st(3'd1, 3'd0, 6'd6));
    emit(f_b(0));
    repeat (2) @(negedge clk);
    chk("R1 pc in reset", {9'b0, imem_addr}, 16'd0);
    chk("R1 we in reset", {15'b0, dmem_we}, 16'd0);
    run(40);
    chk("R1 register cleared", dmem[5], 16'h0000);
    chk("R1 flags cleared", dmem[6], 16'h0044);
    chk("R8 offset zero holds", {9'b0, imem_addr}, 16'd5);
  endtask

  task automatic t_alu();
    load_start();
    emit(f_li(3'd1, 8'hF0));
    emit(f_li(3'd2, 8'h3C));
    emit(f_r(4'h0, 3'd3, 3'd1, 3'd2)); emit(f_st(3'd3, 3'd0, 6'd10));
    emit(f_r(4'h1, 3'd3, 3'd1, 3'd2)); emit(f_st(3'd3, 3'd0, 6'd11));
    emit(f_r(4'h5, 3'd3, 3'd1, 3'd2)); emit(f_st(3'd3, 3'd0, 6'd12));
    emit(f_r(4'h6, 3'd3, 3'd1, 3'd2)); emit(f_st(3'd3, 3'd0, 6'd13));
    emit(f_r(4'h7, 3'd4, 3'd1, 3'd0)); emit(f_st(3'd4, 3'd0, 6'd14));
    emit(f_r(4'h2, 3'd3, 3'd4, 3'd0)); emit(f_st(3'd3, 3'd0, 6'd15));
    emit(f_r(4'h3, 3'd3, 3'd4, 3'd0)); emit(f_st(3'd3, 3'd0, 6'd16));
    emit(f_r(4'h4, 3'd3, 3'd4, 3'd0)); emit(f_st(3'd3, 3'd0, 6'd17));
    emit({4'h8, 3'd5, 1'b1, 8'h9C});   emit(f_st(3'd5, 3'd0, 6'd18));
    emit(16'h9FFF);
    emit(f_st(3'd5, 3'd0, 6'd19));
    emit(f_b(0));
    run(60);
    chk("R3 add", dmem[10], 16'h012C);
    chk("R3 sub", dmem[11], 16'h00B4);
    chk("R3 and", dmem[12], 16'h0030);
    chk("R3 or",  dmem[13], 16'h00FC);
    chk("R3 not", dmem[14], 16'hFF0F);
    chk("R4 shl", dmem[15], 16'hFE1E);
    chk("R4 lsr", dmem[16], 16'h7F87);
    chk("R4 asr", dmem[17], 16'hFF87);
    chk("R6 reserved bit ignored", dmem[18], 16'h009C);
    chk("R12 nop keeps registers", dmem[19], 16'h009C);
    chk("R12 nop writes no memory", wcount[15:0], 16'd10);
    chk("R2 halt address", {9'b0, imem_addr}, 16'd22);
  endtask

  task automatic fcase(logic [15:0] aluw, logic [3:0] mask, logic [5:0] slot);
    emit(f_li(3'd5, 8'hAA));
    emit(aluw);
    emit(f_bc(mask, 2));
    emit(f_li(3'd5, 8'h55));
    emit(f_st(3'd5, 3'd0, slot));
  endtask

  task automatic t_flags();
    load_start();
    emit(f_li(3'd1, 8'hFF)); emit(f_r(4'h7, 3'd1, 3'd1, 3'd0));   // r1 = FF00
    emit(f_li(3'd2, 8'h80)); emit(f_r(4'h7, 3'd2, 3'd2, 3'd0));   // r2 = FF7F
    emit(f_r(4'h3, 3'd2, 3'd2, 3'd0));                            // r2 = 7FBF
    emit(f_li(3'd4, 8'h01));
    fcase(f_r(4'h0, 3'd3, 3'd1, 3'd1), 4'b0010, 6'd20);
    fcase(f_r(4'h0, 3'd3, 3'd1, 3'd1), 4'b0001, 6'd21);
    fcase(f_r(4'h0, 3'd3, 3'd2, 3'd2), 4'b0001, 6'd22);
    fcase(f_r(4'h0, 3'd3, 3'd2, 3'd2), 4'b0010, 6'd23);
    fcase(f_r(4'h1, 3'd3, 3'd2, 3'd2), 4'b1000, 6'd24);
    fcase(f_r(4'h1, 3'd3, 3'd2, 3'd2), 4'b0100, 6'd25);
    fcase(f_r(4'h1, 3'd3, 3'd2, 3'd2), 4'b0010, 6'd26);
    fcase(f_r(4'h1, 3'd3, 3'd0, 3'd4), 4'b0010, 6'd27);
    fcase(f_r(4'h1, 3'd3, 3'd1, 3'd2), 4'b0001, 6'd28);
    fcase(f_r(4'h1, 3'd3, 3'd1, 3'd2), 4'b0010, 6'd29);
    fcase(f_r(4'h2, 3'd3, 3'd1, 3'd0), 4'b0010, 6'd30);
    fcase(f_r(4'h3, 3'd3, 3'd1, 3'd0), 4'b0010, 6'd31);
    emit(f_li(3'd5, 8'hAA));
    emit(f_r(4'h1, 3'd3, 3'd2, 3'd2));
    emit(f_li(3'd6, 8'h07));
    emit(f_st(3'd6, 3'd0, 6'd33));
    emit(f_ld(3'd6, 3'd0, 6'd33));
    emit(16'h9000);
    emit(f_bc(4'b1000, 2));
    emit(f_li(3'd5, 8'h55));
    emit(f_st(3'd5, 3'd0, 6'd32));
    emit(f_b(0));
    run(150);
    chk("R5 add carry out",        dmem[20], 16'h00AA);
    chk("R5 add no overflow",      dmem[21], 16'h0055);
    chk("R5 add overflow",         dmem[22], 16'h00AA);
    chk("R5 add no carry",         dmem[23], 16'h0055);
    chk("R7 zero branch taken",    dmem[24], 16'h00AA);
    chk("R7 negative not taken",   dmem[25], 16'h0055);
    chk("R5 sub no borrow",        dmem[26], 16'h0055);
    chk("R5 sub borrow",           dmem[27], 16'h00AA);
    chk("R5 sub mixed overflow",   dmem[28], 16'h00AA);
    chk("R5 sub mixed no borrow",  dmem[29], 16'h0055);
    chk("R5 shl carry",            dmem[30], 16'h00AA);
    chk("R5 lsr no carry",         dmem[31], 16'h0055);
    chk("R5 flags held over non-ALU", dmem[32], 16'h00AA);
  endtask

  task automatic t_wrap();
    load_start();
    rom[0]   = f_bc(4'b1000, 5);
    rom[1]   = f_b(-3);
    rom[126] = f_li(3'd1, 8'h5A);
    rom[127] = f_r(4'h5, 3'd2, 3'd0, 3'd0);
    rom[5]   = f_st(3'd1, 3'd0, 6'd0);
    rom[6]   = f_b(0);
    run(40);
    chk("R8 backward wrap then R2 sequential wrap", dmem[0], 16'h005A);
    chk("R7 forward target", {9'b0, imem_addr}, 16'd6);
  endtask

  task automatic t_call();
    load_start();
    rom[0]  = f_call(3'd7, 8'd20);
    rom[1]  = f_st(3'd7, 3'd0, 6'd30);
    rom[2]  = f_call(3'd3, 8'd24);
    rom[3]  = f_st(3'd3, 3'd0, 6'd32);
    rom[4]  = f_b(0);
    rom[20] = f_li(3'd1, 8'h77);
    rom[21] = f_st(3'd1, 3'd0, 6'd31);
    rom[22] = f_ret(3'd7);
    rom[24] = f_ret(3'd3);
    run(40);
    chk("R10 link value r7", dmem[30], 16'h0001);
    chk("R10 callee ran", dmem[31], 16'h0077);
    chk("R11 return through r3", dmem[32], 16'h0003);
    chk("R11 final pc", {9'b0, imem_addr}, 16'd4);
  endtask

  task automatic t_mem();
    load_start();
    dmem[45] = 16'h1234;
    emit(f_li(3'd2, 8'd40));
    emit(f_ld(3'd3, 3'd2, 6'd5));
    emit(f_st(3'd3, 3'd2, 6'd63));
    emit(f_b(0));
    run(30);
    chk("R9 load then store offset", dmem[103], 16'h1234);
    chk("R9 single write", wcount[15:0], 16'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_flags();
    t_wrap();
    t_call();
    t_mem();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule